// File: doc/BRIEF.md
# Big-Endian Byte and Word Load/Store Unit

This block sits between a processor core and a word-wide synchronous data memory. It takes one request at a time: a byte address, a two-bit operation code and 32 bits of store data. From these it produces the word index, the per-byte write strobes and the write data for the memory. When load data comes back from the memory it returns the value to the core, already aligned. It supports full-word loads and stores and single-byte loads and stores.

Byte lanes use big-endian numbering. Byte offset 0 of a word is the most significant byte, bits 31..24. A byte load takes its byte from the lane that the offset selects, places it in bits 7..0 and copies its bit 7 into bits 31..8. A byte store puts the low 8 bits of the store data on all four lanes and raises the strobe of exactly one lane. A word request whose address is not a multiple of 4 is flagged. It reaches the memory neither as a read nor as a write.

The memory is assumed to return read data one clock after an enabled read. The unit keeps the operation kind and byte offset of a load for that one cycle, so it can position the returned word.

Top module: `be_ldst_unit`

## Requirements
- R1: `mem_addr` equals bits 31..2 of `req_addr` whenever the request goes to memory.
- R2: The operation code is `req_op` = 00 for word load, 01 for byte load, 10 for word store and 11 for byte store. An aligned word load returns the memory word unchanged on `ld_data`, so the byte at the lowest address appears in bits 31..24.
- R3: A byte load at offset k (address bits 1..0) returns memory bits [31-8k : 24-8k] in `ld_data` bits 7..0.
- R4: A byte load copies bit 7 of the selected byte into `ld_data` bits 31..8.
- R5: An aligned word store drives `mem_we` = 1111 and `mem_wdata` = `req_wdata` in the same cycle as the request.
- R6: A byte store at offset k drives exactly one strobe, `mem_we` bit 3-k (offset 0 is bit 3, the 31..24 lane), and drives `req_wdata[7:0]` on all four byte lanes of `mem_wdata`. No other byte of memory changes.
- R7: A word request with nonzero address bits 1..0 raises `align_err` in the request cycle. It keeps `mem_en` low and `mem_we` at 0000, and it leaves memory unchanged.
- R8: `ld_valid` is high exactly one cycle after each accepted load request and at no other time. Stores and misaligned requests never produce it.
- R9: After reset, with no request, `ld_valid`, `mem_en`, `mem_we` and `align_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 00 LW, 01 LB, 10 SW, 11 SB |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (byte stores use bits 7..0) |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | 30 | Word index into memory |
| mem_we | output | 4 | Byte write strobes, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Write data positioned on lanes |
| mem_rdata | input | 32 | Memory read word, one cycle after read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned, sign-extended load result |
| align_err | output | 1 | Misaligned word access flagged |

## Verification
Directed sequences first store one byte at each of the four offsets of a word, then read the word back whole. This separates correct big-endian lane mapping from little-endian or shifted mappings. Byte loads of values with bit 7 set and clear separate sign extension from zero fill. Word loads and stores at offsets 1, 2 and 3, each followed by a read-back, show that a flagged access neither writes nor returns data. A long run of seeded random mixed operations over a small aliased address window is compared against a byte-granular reference model. It catches stale or mislaned data that appears only after interleaved stores.

// File: rtl/be_ldst_unit.sv
module be_ldst_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          mem_en,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  output logic          align_err
);

  logic       is_store, is_byte, misalign;
  logic [3:0] lane_oh;
  logic       pend_vld, pend_byte;
  logic [1:0] pend_off;
  logic [7:0] sel_byte;

  assign is_store = req_op[1];
  assign is_byte  = req_op[0];
  assign misalign = ~is_byte & (req_addr[1:0] != 2'b00);

  assign align_err = req_valid & misalign;
  assign mem_en    = req_valid & ~misalign;
  assign mem_addr  = req_addr[AW-1:2];
  assign lane_oh   = 4'b1000 >> req_addr[1:0];

  assign mem_we    = (mem_en && is_store) ? (is_byte ? lane_oh : 4'hF) : 4'h0;
  assign mem_wdata = is_byte ? {4{req_wdata[7:0]}} : req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_byte <= 1'b0;
      pend_off  <= 2'b00;
    end else begin
      pend_vld  <= mem_en & ~is_store;
      pend_byte <= is_byte;
      pend_off  <= req_addr[1:0];
    end
  end

  always_comb begin
    case (pend_off)
      2'd0:    sel_byte = mem_rdata[31:24];
      2'd1:    sel_byte = mem_rdata[23:16];
      2'd2:    sel_byte = mem_rdata[15:8];
      default: sel_byte = mem_rdata[7:0];
    endcase
  end

  assign ld_valid = pend_vld;
  assign ld_data  = pend_byte ? {{24{sel_byte[7]}}, sel_byte} : mem_rdata;

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_en && mem_we == 4'h0));

  // R6
  byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |-> $onehot(mem_we));

  // R5
  write_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 4'h0) |-> (req_valid && req_op[1]));

  // R8
  ld_valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op[1] && !align_err) |=> ld_valid);

  // R8
  no_ld_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op[1] || align_err) |=> !ld_valid);

  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |=> (ld_data[31:8] == {24{ld_data[7]}}));

endmodule

// File: tb/be_ldst_unit_bench.sv
`timescale 1ns/1ps
module be_ldst_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_en;
  logic [29:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        align_err;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:15];
  logic [7:0]  refb [0:63];

  always #2 clk = ~clk;

  be_ldst_unit u_be_ldst_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .align_err(align_err));

  always @(posedge clk) begin
    if (mem_en) begin
      for (int k = 0; k < 4; k++)
        if (mem_we[k]) mem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
      mem_rdata <= mem[mem_addr[3:0]];
    end
  end

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 5) ^ (i << 3));
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] a);
    int b = {26'd0, a[5:2], 2'b00};
    return {refb[b], refb[b+1], refb[b+2], refb[b+3]};
  endfunction

  function automatic logic [31:0] exp_byte(logic [31:0] a);
    logic [7:0] v = refb[a[5:0]];
    return {{24{v[7]}}, v};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd);
    logic mis;
    logic [31:0] expd;
    logic [3:0] expwe;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    #1;
    mis  = !op[0] && (a[1:0] != 2'b00);
    expd = op[0] ? exp_byte(a) : exp_word(a);
    check(align_err == mis, "R7 align_err", {31'd0, align_err}, {31'd0, mis});
    check(mem_en == !mis, "R7 mem_en", {31'd0, mem_en}, {31'd0, !mis});
    if (mis) check(mem_we == 4'h0, "R7 no write", {28'd0, mem_we}, 32'd0);
    else check(mem_addr == a[31:2], "R1 word address", {2'b0, mem_addr}, {2'b0, a[31:2]});
    if (op[1] && !mis) begin
      expwe = op[0] ? (4'b1000 >> a[1:0]) : 4'hF;
      if (op[0]) begin
        check(mem_we == expwe, "R6 byte strobe", {28'd0, mem_we}, {28'd0, expwe});
        check(mem_wdata == {4{wd[7:0]}}, "R6 replicated data", mem_wdata, {4{wd[7:0]}});
        refb[a[5:0]] = wd[7:0];
      end else begin
        check(mem_we == expwe, "R5 word strobe", {28'd0, mem_we}, {28'd0, expwe});
        check(mem_wdata == wd, "R5 word data", mem_wdata, wd);
        for (int k = 0; k < 4; k++) refb[{a[5:2], 2'b00} + k] = wd[31-8*k -: 8];
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(ld_valid == (!op[1] && !mis), "R8 ld_valid", {31'd0, ld_valid}, {31'd0, !op[1] && !mis});
    if (!op[1] && !mis) begin
      if (op[0]) check(ld_data == expd, "R3 R4 byte load", ld_data, expd);
      else check(ld_data == expd, "R2 word load", ld_data, expd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 64; i++) refb[i] = init_byte(i);
    for (int w = 0; w < 16; w++)
      mem[w] = {refb[4*w], refb[4*w+1], refb[4*w+2], refb[4*w+3]};
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R9 reset state
    check(!ld_valid && !mem_en && mem_we == 4'h0 && !align_err, "R9 idle after reset",
          {28'd0, ld_valid, mem_en, align_err, |mem_we}, 32'd0);
    // R6 each lane, then R2 readback shows big-endian placement
    do_op(2'b11, 32'd8,  32'hFFFF_FF11);
    do_op(2'b11, 32'd9,  32'h0000_0022);
    do_op(2'b11, 32'd10, 32'h1234_5633);
    do_op(2'b11, 32'd11, 32'h0000_0044);
    do_op(2'b00, 32'd8,  32'd0);
    check(ld_data == 32'h11223344, "R2 R6 lane order", ld_data, 32'h11223344);
    // R4 negative and positive bytes, R3 each offset
    do_op(2'b10, 32'd16, 32'h80_7F_FF_01);
    for (int k = 0; k < 4; k++) do_op(2'b01, 32'd16 + k, 32'd0);
    // R7 misaligned word accesses leave memory intact
    for (int k = 1; k < 4; k++) begin
      do_op(2'b10, 32'd16 + k, 32'hDEAD_BEEF);
      do_op(2'b00, 32'd16 + k, 32'd0);
    end
    do_op(2'b00, 32'd16, 32'd0);
    check(ld_data == 32'h807FFF01, "R7 memory unchanged", ld_data, 32'h807FFF01);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra;
      ra = {$urandom} & 32'hFFFF_FFFF;
      do_op(2'($urandom % 4), ra, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule